// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block turns single host commands into management frames on a two-wire PHY management bus. The bus has a clock line that the master drives and one bidirectional data line. The data line is presented as an output value, an output enable and an input. A command is a read or a write, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The host pulses `cmdStart` while `busy` is low. Once the frame is over, the block pulses `done` for one cycle. After a read it also presents the register contents and an acknowledge-error flag.

Every frame has the same length: 65 management-clock slots. Each slot is one low half and one high half of the management clock, and each half lasts `HALF_DIV` system clocks. Slot k means the k-th rising edge of the management clock in the frame, counting from 0.

The frame starts with a preamble of ones, followed by the header and then the body:

- **Write body:** a turnaround pattern, the data and an idle slot. The master drives the line for the whole frame.
- **Read body:** the master lets go of the line after the header. It checks for an acknowledge, clocks in the data and ends with an idle slot.
- **Read with no acknowledge:** the master still clocks through all of the data slots, so that every PHY on the bus stays aligned to the frame. It then reports zero data and raises the error flag.

Top module: `mdio_master`

## Requirements
- R1: Slots 0 to 31 form the preamble: at each of these rising edges the data line is driven (enable 1) and high.
- R2: Slots 32 to 45 carry the header, MSB first and driven: start code 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register address.
- R3: In a write, slots 46 and 47 carry the turnaround pattern 10, and slots 48 to 63 carry the write data MSB first. Slot 64 is an idle slot driven high. The line is driven through all 65 slots and released after slot 64. At `done`, `ackErr` reads 0.
- R4: In a read, the line is released (enable 0) from slot 46 through slot 64. The input is sampled at the rising edge of slot 47 as the acknowledge: 0 means a PHY answered.
- R5: In an acknowledged read, the input sampled at the rising edges of slots 48 to 63 is assembled MSB first into `rdData`. `rdData` is valid with `ackErr` = 0 when `done` pulses.
- R6: If the acknowledge sample is 1, the frame still runs all 65 slots. `rdData` then reads 0 and `ackErr` reads 1 at `done`.
- R7: The data output and the enable change only while the management clock is low. Each clock half lasts `HALF_DIV` system clocks, and the management clock is low whenever the block is idle.
- R8: `busy` rises on the edge that accepts `cmdStart` and falls when `done` rises. `done` is a one-cycle pulse, first visible 130×`HALF_DIV` system clocks after the accepting edge.
- R9: A `cmdStart` seen while `busy` is high is ignored: the frame in flight is unchanged and no second frame follows.
- R10: After reset, `mdc`, `mdioOe`, `busy`, `done`, `ackErr` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Command request, accepted while not busy |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdPhyAddr | input | 5 | Target PHY address |
| cmdRegAddr | input | 5 | Target register address |
| cmdWrData | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Data from the last read |
| ackErr | output | 1 | Last read got no acknowledge |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line drive value |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line sampled value |

## Verification
The bench builds the block with `HALF_DIV` = 2, so one frame lasts 260 system clocks. This is short enough to sweep all 32 PHY addresses, each with a write, an acknowledged read and, on every fourth address, a read that gets no acknowledge.

A bus responder in the bench records the drive value and the enable at every rising edge of the management clock. Each recorded slot is compared against a frame the bench builds itself from the command. The same responder supplies the acknowledge and the read data.

During each frame the bench also issues a stray start pulse. This checks that the frame in flight is unchanged and that the block stays idle afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  // Strobes and levels from the sequencer to the datapath
  typedef struct packed {
    logic load;        // latch a new command
    logic shift;       // advance the outgoing frame by one bit
    logic sampleAck;   // capture the acknowledge sample
    logic sampleData;  // shift in one read data bit
    logic finish;      // publish results
    logic drivePre;    // preamble slot: drive a one
    logic driveIdle;   // final idle slot: drive a one
  } dpCtrl_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int PRE_LEN  = 32,
  parameter int HDR_W    = 14,
  parameter int DATA_W   = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmdStart,
  input  logic    cmdWrite,
  output logic    busy,
  output logic    done,
  output logic    mdc,
  output logic    mdioOe,
  output logic    isWrite,
  output dpCtrl_t ctl
);

  localparam int SLOT_LAST_I = PRE_LEN + HDR_W + 2 + DATA_W;
  localparam int SLOT_W      = $clog2(SLOT_LAST_I + 1);
  localparam int DIV_W       = $clog2(HALF_DIV + 1);

  localparam logic [SLOT_W-1:0] S_PRE  = SLOT_W'(PRE_LEN);
  localparam logic [SLOT_W-1:0] S_REL  = SLOT_W'(PRE_LEN + HDR_W);
  localparam logic [SLOT_W-1:0] S_ACK  = SLOT_W'(PRE_LEN + HDR_W + 1);
  localparam logic [SLOT_W-1:0] S_D0   = SLOT_W'(PRE_LEN + HDR_W + 2);
  localparam logic [SLOT_W-1:0] S_LAST = SLOT_W'(SLOT_LAST_I);
  localparam logic [DIV_W-1:0]  DIV_TOP = DIV_W'(HALF_DIV - 1);

  logic              running;
  logic              phaseHigh;
  logic              writeR;
  logic              doneR;
  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slot;
  logic              tick;

  assign tick = running && (divCnt == DIV_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      phaseHigh <= 1'b0;
      writeR    <= 1'b0;
      doneR     <= 1'b0;
      divCnt    <= '0;
      slot      <= '0;
    end else begin
      doneR <= 1'b0;
      if (!running) begin
        if (cmdStart) begin
          running   <= 1'b1;
          writeR    <= cmdWrite;
          divCnt    <= '0;
          phaseHigh <= 1'b0;
          slot      <= '0;
        end
      end else if (tick) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          if (slot == S_LAST) begin
            running <= 1'b0;
            doneR   <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = !running && cmdStart;
    ctl.shift      = tick && phaseHigh && (slot >= S_PRE) && (slot != S_LAST);
    ctl.sampleAck  = tick && !phaseHigh && !writeR && (slot == S_ACK);
    ctl.sampleData = tick && !phaseHigh && !writeR && (slot >= S_D0) && (slot != S_LAST);
    ctl.finish     = tick && phaseHigh && (slot == S_LAST);
    ctl.drivePre   = slot < S_PRE;
    ctl.driveIdle  = slot == S_LAST;
  end

  assign busy    = running;
  assign done    = doneR;
  assign mdc     = phaseHigh;
  assign isWrite = writeR;
  assign mdioOe  = running && ((slot < S_REL) || writeR);

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int TX_W   = 4 + 2 * ADDR_W + 2 + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic              isWrite,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData,
  output logic              ackErr
);

  logic [TX_W-1:0]   txReg;
  logic [DATA_W-1:0] rxReg;
  logic              noAck;
  logic [DATA_W-1:0] rdDataR;
  logic              ackErrR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txReg   <= '0;
      rxReg   <= '0;
      noAck   <= 1'b0;
      rdDataR <= '0;
      ackErrR <= 1'b0;
    end else begin
      if (ctl.load) begin
        txReg <= {START_CODE, (cmdWrite ? OP_WRITE : OP_READ),
                  cmdPhyAddr, cmdRegAddr, TA_WRITE, cmdWrData};
        rxReg <= '0;
        noAck <= 1'b0;
      end else if (ctl.shift) begin
        txReg <= {txReg[TX_W-2:0], 1'b0};
      end
      if (ctl.sampleAck) noAck <= mdioIn;
      if (ctl.sampleData) rxReg <= {rxReg[DATA_W-2:0], mdioIn & ~noAck};
      if (ctl.finish) begin
        if (isWrite) begin
          ackErrR <= 1'b0;
        end else begin
          rdDataR <= rxReg;
          ackErrR <= noAck;
        end
      end
    end
  end

  assign mdioOut = (ctl.drivePre || ctl.driveIdle) ? 1'b1 : txReg[TX_W-1];
  assign rdData  = rdDataR;
  assign ackErr  = ackErrR;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int PRE_LEN  = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              ackErr,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int HDR_W = 4 + 2 * ADDR_W;
  localparam int TX_W  = HDR_W + 2 + DATA_W;

  dpCtrl_t ctl;
  logic    isWrite;

  mdio_ctrl #(
    .HALF_DIV(HALF_DIV), .PRE_LEN(PRE_LEN), .HDR_W(HDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .busy(busy), .done(done), .mdc(mdc), .mdioOe(mdioOe),
    .isWrite(isWrite), .ctl(ctl)
  );

  mdio_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_W(TX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .isWrite(isWrite),
    .cmdWrite(cmdWrite), .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr),
    .cmdWrData(cmdWrData), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .rdData(rdData), .ackErr(ackErr)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdStart,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              ackErr,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe
);

  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdioOe)); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && !busy) |=> busy); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_NOACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ackErr) |-> (rdData == '0)); // R6

endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .busy(busy), .done(done),
  .rdData(rdData), .ackErr(ackErr), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

  localparam int H     = 2;
  localparam int SLOTS = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdStart = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [4:0]  cmdPhyAddr = '0;
  logic [4:0]  cmdRegAddr = '0;
  logic [15:0] cmdWrData = '0;
  logic        busy, done, ackErr, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr), .cmdWrData(cmdWrData),
    .busy(busy), .done(done), .rdData(rdData), .ackErr(ackErr),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // Bus responder: records every rising edge, answers reads
  int          k = 0;
  int          startK = 0;
  logic        phyAck = 1'b1;
  logic [15:0] phyData = '0;
  logic        recOut [0:SLOTS-1];
  logic        recOe  [0:SLOTS-1];

  always @(posedge mdc) begin
    int kk;
    kk = k - startK;
    if (kk >= 0 && kk < SLOTS) begin
      recOut[kk] = mdioOut;
      recOe[kk]  = mdioOe;
    end
    if (kk == 46) mdioIn = phyAck ? 1'b0 : 1'b1;
    else if (kk >= 47 && kk <= 62) mdioIn = phyData[62 - kk];
    else mdioIn = 1'b1;
    k = k + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] frameBits(input bit wr, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, d};
  endfunction

  function automatic logic expOe(input bit wr, input int s);
    return wr ? 1'b1 : (s < 46);
  endfunction

  function automatic logic expOut(input logic [31:0] f, input int s);
    if (s < 32 || s == 64) return 1'b1;
    return f[63 - s];
  endfunction

  task automatic runTxn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] d, input bit ack, input logic [15:0] pd);
    int n;
    int badSlot;
    logic [31:0] f;
    logic [15:0] oldRd;
    f = frameBits(wr, pa, ra, d);
    oldRd = rdData;
    phyAck = ack;
    phyData = pd;
    startK = k;
    @(negedge clk);
    cmdStart = 1'b1; cmdWrite = wr; cmdPhyAddr = pa; cmdRegAddr = ra; cmdWrData = d;
    n = 0;
    while (!done && n < 200 * H) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        cmdStart = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
      end
      if (n == 10) begin
        cmdStart = 1'b1; cmdWrite = ~wr; cmdPhyAddr = ~pa; cmdRegAddr = ~ra; cmdWrData = ~d;
      end
      if (n == 11) cmdStart = 1'b0;
    end
    check(n == 130 * H + 1, "R8 done latency", n, 130 * H + 1);
    check(busy == 1'b0, "R8 busy clear at done", busy, 0);
    check((k - startK) == SLOTS, "R6 slot count", k - startK, SLOTS);
    badSlot = -1;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (recOe[s] !== expOe(wr, s)) badSlot = s;
      else if (recOe[s] && recOut[s] !== expOut(f, s)) badSlot = s;
    end
    if (wr) check(badSlot < 0, "R1 R2 R3 write frame, first bad slot", badSlot, -1);
    else    check(badSlot < 0, "R1 R2 R4 read frame, first bad slot", badSlot, -1);
    if (wr) begin
      check(ackErr == 1'b0, "R3 ackErr after write", ackErr, 0);
      check(rdData == oldRd, "R3 rdData kept on write", rdData, oldRd);
    end else if (ack) begin
      check(rdData == pd, "R5 read data", rdData, pd);
      check(ackErr == 1'b0, "R5 ackErr on ack", ackErr, 0);
    end else begin
      check(rdData == 16'h0, "R6 read data on no ack", rdData, 0);
      check(ackErr == 1'b1, "R6 ackErr on no ack", ackErr, 1);
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    repeat (3 * H) @(negedge clk);
    check(busy == 1'b0 && mdc == 1'b0, "R9 no second frame", {busy, mdc}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({mdc, mdioOe, busy, done, ackErr} == 5'b0, "R10 reset outputs",
          {mdc, mdioOe, busy, done, ackErr}, 0);
    check(rdData == 16'h0, "R10 reset rdData", rdData, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R7 idle line quiet", {mdc, mdioOe}, 0);
    for (int p = 0; p < 32; p++) begin
      logic [15:0] wd;
      logic [15:0] pd;
      wd = 16'(p * 2053) ^ 16'hA5C3;
      pd = 16'(p * 40503) ^ 16'h5A0F;
      runTxn(1'b1, 5'(p), 5'(31 - p), wd, 1'b1, 16'h0);
      runTxn(1'b0, 5'(p), 5'(p ^ 5'h15), 16'h0, 1'b1, pd);
      if (p % 4 == 3) runTxn(1'b0, 5'(p), 5'(p), 16'h0, 1'b0, 16'hFFFF);
    end
    runTxn(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'hFFFF);
    runTxn(1'b0, 5'h00, 5'h00, 16'h0, 1'b1, 16'h0000);
    runTxn(1'b1, 5'h1F, 5'h00, 16'hFFFF, 1'b1, 16'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule